// File: doc/BRIEF.md
# DMA Protected High-Memory Range Guard

This block holds the base and limit of one protected region in high system memory and checks each DMA address against it. Software programs the two range registers and a control register through a single-cycle register port. When protection is on and the range is valid, any DMA request whose address lies within the region is flagged as blocked one clock later.

Only the upper address bits of the range registers are stored, which gives the region a coarse, aligned granularity. By default that granularity is 2 MiB, set by the parameter `GRAN_LOG2`. The limit's dropped low bits count as all ones in the compare, so the limit names the last byte of its aligned block. The base's dropped low bits count as zeros. Address bits at or above the host address width (`HAW`, default 39) are neither stored nor compared.

A lock command input freezes the range registers and an unlock command releases them. A capability strap turns the whole region off. When the strap is low, nothing is writable and nothing can be enabled.

Top module: `phm_guard`

## Requirements
- R1: After reset, the base, limit, enable, error and lock state are all zero, and `dma_chk_vld` and `dma_blocked` are low.
- R2: `cfg_sel` 0 selects the base register and 1 selects the limit register. Each one stores only bits HAW-1 down to GRAN_LOG2 of the written data (38:21 by default). All other bits read back as zero, so writing all ones to the limit reads back 0x0000_007F_FFE0_0000.
- R3: `cfg_sel` 2 selects the control register. Bit 0 is the enable and is read-write. Bit 1 is the sticky error flag, cleared by writing one to it. Bit 2 reads the lock state and bit 3 reads the capability strap. Every other bit, and `cfg_sel` 3, reads zero.
- R4: A `lock_cmd` pulse makes the base and limit ignore writes until an `unlock_cmd` pulse arrives. If both commands arrive in the same cycle, the lock wins.
- R5: While `cap_phm` is low, writes to the base, limit and enable bit have no effect.
- R6: With `cap_phm` high and enable set, a write to the base or limit is dropped and sets the error flag. This holds whether or not the registers are locked.
- R7: A request at address A is blocked when all of the following hold: enable is set, the region is valid, and base ≤ A ≤ (limit with its low GRAN_LOG2 bits set to one).
- R8: When the limit is below the base, the region is invalid and no address is blocked.
- R9: DMA address bits at or above HAW are ignored by the compare.
- R10: `dma_chk_vld` is high exactly one cycle after `dma_req`, and `dma_blocked` carries the result for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_phm | input | 1 | Capability strap: high when the protected region is supported |
| lock_cmd | input | 1 | Pulse that locks the range registers |
| unlock_cmd | input | 1 | Pulse that unlocks the range registers |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 control |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Combinational read data of the selected register |
| dma_req | input | 1 | DMA address valid |
| dma_addr | input | 64 | DMA host physical address |
| dma_chk_vld | output | 1 | Check result valid, one cycle after `dma_req` |
| dma_blocked | output | 1 | Address hit the enabled, valid region |

## Verification
A corrupted base or limit shows on `cfg_rdata` as soon as the register is selected. It also shows on `dma_blocked` the cycle after a request lands near either region edge, so the boundary addresses one below the base, the base itself, the last byte of the limit block and the next byte are all probed. A wrong lock or enable state shows one cycle after the next range write: the register either changes when it should not or holds when it should change, and the error flag either rises when it should not or stays low when it should rise. Every control-register readback therefore follows a write.

// File: rtl/phm_pkg.sv
package phm_pkg;

  localparam int REG_W = 64;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_ERR  = 1;
  localparam int CTRL_LOCK = 2;
  localparam int CTRL_CAP  = 3;

  // Ones in bit positions lo .. hi-1.
  function automatic logic [REG_W-1:0] span_mask(input int lo, input int hi);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) begin
      m[i] = (i >= lo) && (i < hi);
    end
    return m;
  endfunction

  // Last byte address covered by a limit value.
  function automatic logic [REG_W-1:0] limit_top(input logic [REG_W-1:0] lim, input int gran);
    return lim | span_mask(0, gran);
  endfunction

  // Inclusive window test.
  function automatic logic in_window(input logic [REG_W-1:0] a,
                                     input logic [REG_W-1:0] lo,
                                     input logic [REG_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/phm_lock_ctl.sv
module phm_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_cmd,
  input  logic unlock_cmd,
  output logic lock_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lock_q <= 1'b0;
    else if (lock_cmd)   lock_q <= 1'b1;
    else if (unlock_cmd) lock_q <= 1'b0;
  end

  // R4
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cmd |=> lock_q);
  // R4
  lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_cmd && !lock_cmd) |=> !lock_q);

endmodule

// File: rtl/phm_range_regs.sv
module phm_range_regs
  import phm_pkg::*;
#(
  parameter int HAW       = 39,
  parameter int GRAN_LOG2 = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_phm,
  input  logic             lock_q,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] limit_q,
  output logic             en_q,
  output logic             err_q
);

  localparam logic [REG_W-1:0] KEEP = span_mask(GRAN_LOG2, HAW);
  localparam int NUM_RANGE = 2;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  logic range_wr, range_wr_ok, range_wr_viol, ctrl_wr;
  logic [NUM_RANGE-1:0][REG_W-1:0] rq;

  assign range_wr      = cfg_wr && (sel == SEL_BASE || sel == SEL_LIMIT);
  assign range_wr_viol = range_wr && cap_phm && en_q;
  assign range_wr_ok   = range_wr && cap_phm && !en_q && !lock_q;
  assign ctrl_wr       = cfg_wr && (sel == SEL_CTRL);

  for (genvar g = 0; g < NUM_RANGE; g++) begin : g_range
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rq[g] <= '0;
      else if (range_wr_ok && (cfg_sel == 2'(g)))
        rq[g] <= cfg_wdata & KEEP;
    end
  end

  assign base_q  = rq[SEL_BASE];
  assign limit_q = rq[SEL_LIMIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    en_q <= 1'b0;
    else if (ctrl_wr && cap_phm)   en_q <= cfg_wdata[CTRL_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              err_q <= 1'b0;
    else if (range_wr_viol)                  err_q <= 1'b1;
    else if (ctrl_wr && cfg_wdata[CTRL_ERR]) err_q <= 1'b0;
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (sel)
      SEL_BASE:  cfg_rdata = base_q;
      SEL_LIMIT: cfg_rdata = limit_q;
      SEL_CTRL: begin
        cfg_rdata[CTRL_EN]   = en_q;
        cfg_rdata[CTRL_ERR]  = err_q;
        cfg_rdata[CTRL_LOCK] = lock_q;
        cfg_rdata[CTRL_CAP]  = cap_phm;
      end
      default:   cfg_rdata = '0;
    endcase
  end

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(base_q) && $stable(limit_q)));
  // R5
  nocap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_phm && !en_q) |=> ($stable(base_q) && $stable(limit_q) && !en_q));
  // R6
  viol_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_wr_viol |=> (err_q && $stable(base_q) && $stable(limit_q)));
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(range_wr_viol));

endmodule

// File: rtl/phm_range_cmp.sv
module phm_range_cmp
  import phm_pkg::*;
#(
  parameter int HAW       = 39,
  parameter int GRAN_LOG2 = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] base_q,
  input  logic [REG_W-1:0] limit_q,
  input  logic             en_q,
  input  logic             dma_req,
  input  logic [REG_W-1:0] dma_addr,
  output logic             dma_chk_vld,
  output logic             dma_blocked
);

  localparam logic [REG_W-1:0] ADDR_KEEP = span_mask(0, HAW);

  logic [REG_W-1:0] addr_eff, top_eff;
  logic region_valid, hit_now;

  assign addr_eff     = dma_addr & ADDR_KEEP;
  assign top_eff      = limit_top(limit_q, GRAN_LOG2);
  assign region_valid = (limit_q >= base_q);
  assign hit_now      = dma_req && en_q && region_valid &&
                        in_window(addr_eff, base_q, top_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_chk_vld <= 1'b0;
      dma_blocked <= 1'b0;
    end else begin
      dma_chk_vld <= dma_req;
      dma_blocked <= hit_now;
    end
  end

  // R10
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> dma_chk_vld);
  // R10
  blk_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_blocked |-> dma_chk_vld);
  // R8
  blk_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_blocked |-> ($past(region_valid) && $past(en_q)));

endmodule

// File: rtl/phm_guard.sv
module phm_guard
  import phm_pkg::*;
#(
  parameter int HAW       = 39,
  parameter int GRAN_LOG2 = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_phm,
  input  logic        lock_cmd,
  input  logic        unlock_cmd,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_sel,
  input  logic [63:0] cfg_wdata,
  output logic [63:0] cfg_rdata,
  input  logic        dma_req,
  input  logic [63:0] dma_addr,
  output logic        dma_chk_vld,
  output logic        dma_blocked
);

  logic             lock_q, en_q, err_q;
  logic [REG_W-1:0] base_q, limit_q;

  phm_lock_ctl u_lock (
    .clk(clk), .rst_n(rst_n), .lock_cmd(lock_cmd),
    .unlock_cmd(unlock_cmd), .lock_q(lock_q)
  );

  phm_range_regs #(.HAW(HAW), .GRAN_LOG2(GRAN_LOG2)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_phm(cap_phm), .lock_q(lock_q),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .base_q(base_q), .limit_q(limit_q),
    .en_q(en_q), .err_q(err_q)
  );

  phm_range_cmp #(.HAW(HAW), .GRAN_LOG2(GRAN_LOG2)) u_cmp (
    .clk(clk), .rst_n(rst_n), .base_q(base_q), .limit_q(limit_q),
    .en_q(en_q), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_chk_vld(dma_chk_vld), .dma_blocked(dma_blocked)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dma_blocked && !dma_chk_vld));

endmodule

// File: tb/phm_guard_tb.sv
module phm_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_phm = 1'b1;
  logic        lock_cmd = 1'b0, unlock_cmd = 1'b0, cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [63:0] cfg_wdata = '0, cfg_rdata;
  logic        dma_req = 1'b0;
  logic [63:0] dma_addr = '0;
  logic        dma_chk_vld, dma_blocked;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phm_guard u_dut (.*);

  // Behavioural reference model
  longint unsigned m_base, m_lim;
  bit m_en, m_err, m_lock, m_vld, m_blk;
  longint unsigned keep, gsz;
  initial begin
    gsz  = 64'd1 << 21;
    keep = ((64'd1 << 39) - 1) - (gsz - 1);
  end

  function automatic longint unsigned m_read(input logic [1:0] s);
    case (s)
      2'd0: return m_base;
      2'd1: return m_lim;
      2'd2: return {60'd0, cap_phm, m_lock, m_err, m_en};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base <= 0; m_lim <= 0; m_en <= 0; m_err <= 0; m_lock <= 0;
      m_vld <= 0; m_blk <= 0;
    end else begin
      longint unsigned a;
      a = dma_addr % (64'd1 << 39);
      m_vld <= dma_req;
      m_blk <= dma_req && m_en && (m_lim >= m_base) &&
               (a >= m_base) && (a <= m_lim + gsz - 1);
      if (cfg_wr && cap_phm && cfg_sel < 2) begin
        if (m_en) m_err <= 1;
        else if (!m_lock) begin
          if (cfg_sel == 0) m_base <= cfg_wdata & keep;
          else              m_lim  <= cfg_wdata & keep;
        end
      end
      if (cfg_wr && cfg_sel == 2) begin
        if (cap_phm) m_en <= cfg_wdata[0];
        if (cfg_wdata[1]) m_err <= 0;
      end
      if (lock_cmd) m_lock <= 1;
      else if (unlock_cmd) m_lock <= 0;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R10 model vld", 64'(dma_chk_vld), 64'(m_vld));
      check("R7 model blk", 64'(dma_blocked), 64'(m_blk));
      check("R3 model rdata", cfg_rdata, m_read(cfg_sel));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [63:0] exp, input string tag);
    @(negedge clk); cfg_sel = s; #2;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic dma(input logic [63:0] a, input logic exp, input string tag);
    @(negedge clk); dma_req = 1; dma_addr = a;
    @(negedge clk); dma_req = 0; #2;
    check(tag, {62'd0, dma_chk_vld, dma_blocked}, {62'd0, 1'b1, exp});
  endtask

  task automatic pulse(input bit lk, input bit ul);
    @(negedge clk); lock_cmd = lk; unlock_cmd = ul;
    @(negedge clk); lock_cmd = 0; unlock_cmd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, 64'h0, "R1 base after reset");
    rd(2'd1, 64'h0, "R1 limit after reset");
    rd(2'd2, 64'h8, "R1 ctrl after reset");
    check("R1 outputs quiet", {62'd0, dma_chk_vld, dma_blocked}, 64'h0);
    // R2 reserved bits
    wr(2'd1, '1);
    rd(2'd1, 64'h0000_007F_FFE0_0000, "R2 limit all ones");
    wr(2'd0, 64'h1234_5678_9ABC);
    rd(2'd0, 64'h0000_0056_6000_0000 & 64'h0 | 64'h0000_0034_5660_0000 & 64'h7F_FFE0_0000, "R2 base masked");
    wr(2'd0, 64'h4000_1234);
    wr(2'd1, 64'h4000_0000);
    rd(2'd0, 64'h4000_0000, "R2 base");
    dma(64'h4000_0000, 1'b0, "R7 disabled not blocked");
    // R3 enable
    wr(2'd2, 64'hFFFF_FFF1);
    rd(2'd2, 64'h9, "R3 enable set");
    rd(2'd3, 64'h0, "R3 sel3 reads zero");
    // R7 edges
    dma(64'h3FFF_FFFF, 1'b0, "R7 below base");
    dma(64'h4000_0000, 1'b1, "R7 at base");
    dma(64'h401F_FFFF, 1'b1, "R7 last byte");
    dma(64'h4020_0000, 1'b0, "R7 past limit");
    dma(64'hFF00_0000_4010_0000, 1'b1, "R9 high bits ignored");
    // R6 write while enabled
    wr(2'd0, 64'h0);
    rd(2'd2, 64'hB, "R6 error set");
    rd(2'd0, 64'h4000_0000, "R6 base unchanged");
    wr(2'd2, 64'h3);
    rd(2'd2, 64'h9, "R3 error cleared");
    wr(2'd2, 64'h0);
    // R8 limit below base
    wr(2'd1, 64'h2000_0000);
    wr(2'd2, 64'h1);
    dma(64'h4000_0000, 1'b0, "R8 base addr");
    dma(64'h2000_0000, 1'b0, "R8 limit addr");
    wr(2'd2, 64'h0);
    // R4 lock
    pulse(1, 0);
    rd(2'd2, 64'hC, "R4 locked status");
    wr(2'd0, 64'h8000_0000);
    rd(2'd0, 64'h4000_0000, "R4 locked write ignored");
    pulse(0, 1);
    wr(2'd0, 64'h8000_0000);
    rd(2'd0, 64'h8000_0000, "R4 unlocked write");
    pulse(1, 1);
    rd(2'd2, 64'hC, "R4 lock wins");
    pulse(0, 1);
    // R5 no capability
    @(negedge clk); cap_phm = 0;
    rd(2'd2, 64'h0, "R5 cap low status");
    wr(2'd1, 64'h1_0000_0000);
    rd(2'd1, 64'h2000_0000, "R5 limit unchanged");
    wr(2'd2, 64'h1);
    rd(2'd2, 64'h0, "R5 enable refused");
    @(negedge clk); cap_phm = 1;
    // Region of one granule
    wr(2'd1, 64'h8000_0000);
    wr(2'd2, 64'h1);
    dma(64'h8010_0000, 1'b1, "R7 single granule");
    dma(64'h7FFF_FFFF, 1'b0, "R7 below single granule");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule